// File: doc/BRIEF.md
# Host-to-Engine Word Transfer FIFO

This block sits between a bus host and a small set of processing engines. The host loads 32-bit words into an internal buffer through a simple register port. It programs a word count and picks a destination engine. It then sets a start bit. The block forwards exactly that many words, oldest first, over a valid/ready port to the selected engine. While the engine is not ready, it holds the current word and waits.

One control/status register carries the configuration fields and the progress state. The configuration fields are the access enables, the destination select, a sync option, an error enable and a flush command. The progress state covers the buffer fill and free counts, empty and full flags, and running and done flags. A host access to the buffer or the length register while neither host enable is set can raise a one-cycle bus error. If the sync option is chosen, a started transfer is held back until a companion output FIFO reports that it has finished.

Top module: `host_engine_fifo`

## Requirements
- R1: After reset the control register reads running=0, done=0, empty=1, full=0, fill count 0, free count DEPTH and start (bit 0) 0.
- R2: A host write to the buffer (reg_sel=2) stores the word only when the host-write enable (bit 4) is set. Otherwise the fill count does not change.
- R3: Bits 15:8 give the number of stored words and bits 23:16 give the free slots. Bit 26 is empty and bit 27 is full. A write to a full buffer is dropped.
- R4: Writing 1 to bit 0 while idle arms a transfer. Bit 0 reads 1 only until the transfer starts. After that it reads 0 and running (bit 24) reads 1.
- R5: Words leave in write order on the port selected by bits 7:6, where 0, 1 and 2 select a port and 3 selects none. At most one dst_valid bit is high.
- R6: While the selected ready is low, dst_valid and dst_data hold steady.
- R7: The length register (reg_sel=1) sets how many words one transfer moves. Exactly that many words leave, and any words beyond them stay in the buffer. A length read returns the remaining count.
- R8: When the remaining count reaches zero, running clears and done (bit 25) sets. Done clears when a new start is accepted or on a flush.
- R9: With the sync option (bit 3) set, an armed start waits while sync_done is low. During that wait bit 0 reads 1 and running reads 0.
- R10: Writing the control register with bit 2 set empties the buffer and clears start, running and done.
- R11: With bit 1 set and both host enables clear, a buffer write or a length access raises bus_err for one cycle, one cycle after the access. With bit 1 clear, bus_err stays low.
- R12: When the host-read enable (bit 5) is clear, bits 31:16 of the control register and the length read return zero.
- R13: Host writes to the status fields (bits 31:8) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_sel | input | 2 | 0 control, 1 length, 2 buffer, 3 unused |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Host read data, registered |
| bus_err | output | 1 | Bus error pulse |
| sync_done | input | 1 | Companion output FIFO finished |
| dst_valid | output | NDST | One-hot word valid per engine |
| dst_ready | input | NDST | Per-engine ready |
| dst_data | output | DW | Word being offered |

## Verification
Read data and bus_err are registered, so both appear in the cycle after the access. The bench drives each access at a falling edge and samples at the next falling edge. A start written to the control register turns into running one edge later. For that reason the bench idles at least one cycle before it reads running or the start bit back. The done flag sets one edge after the last handshake, and the bench reaches it by polling within a bounded loop. Handshakes are scored one nanosecond after each falling edge, against a queue filled when the transfer is launched.

// File: rtl/host_engine_fifo.sv
module host_engine_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int LENW  = 16,
  parameter int NDST  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [1:0]      reg_sel,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            bus_err,
  input  logic            sync_done,
  output logic [NDST-1:0] dst_valid,
  input  logic [NDST-1:0] dst_ready,
  output logic [DW-1:0]   dst_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CW-1:0]   fill;
  logic            err_en, sync_en, wr_en, rd_en;
  logic [1:0]      dest;
  logic            start_q, running, done;
  logic [LENW-1:0] len_reg, len_cnt;

  wire ctrl_wr = reg_wr && reg_sel == 2'd0;
  wire len_wr  = reg_wr && reg_sel == 2'd1;
  wire dat_wr  = reg_wr && reg_sel == 2'd2;
  wire clr     = ctrl_wr && wdata[2];
  wire empty   = fill == '0;
  wire full    = fill == CW'(DEPTH);
  wire push    = dat_wr && wr_en && !full && !clr;
  wire sel_ok  = int'(dest) < NDST;
  wire deliver = running && len_cnt != '0 && !empty && sel_ok;
  wire pop     = |(dst_valid & dst_ready);
  wire go      = start_q && (!sync_en || sync_done) && !clr;

  assign dst_valid = deliver ? (NDST'(1) << dest) : '0;
  assign dst_data  = mem[rp];

  always_ff @(posedge clk)
    if (push) mem[wp] <= wdata[DW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; fill <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; fill <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      fill <= fill + CW'(push) - CW'(pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err_en <= 1'b0; sync_en <= 1'b0; wr_en <= 1'b0; rd_en <= 1'b0; dest <= '0;
    end else if (ctrl_wr) begin
      err_en  <= wdata[1];
      sync_en <= wdata[3];
      wr_en   <= wdata[4];
      rd_en   <= wdata[5];
      dest    <= wdata[7:6];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      start_q <= 1'b0; running <= 1'b0; done <= 1'b0;
      len_reg <= '0; len_cnt <= '0;
    end else if (clr) begin
      start_q <= 1'b0; running <= 1'b0; done <= 1'b0;
    end else begin
      if (len_wr && !running) begin
        len_reg <= wdata[LENW-1:0];
        len_cnt <= wdata[LENW-1:0];
      end
      if (ctrl_wr && wdata[0] && !running && !start_q) begin
        start_q <= 1'b1;
        done    <= 1'b0;
      end
      if (go) begin
        start_q <= 1'b0;
        running <= 1'b1;
        len_cnt <= len_reg;
      end else if (running && len_cnt == '0) begin
        running <= 1'b0;
        done    <= 1'b1;
      end else if (pop) begin
        len_cnt <= len_cnt - 1'b1;
      end
    end

  wire [15:0] st_hi = {4'b0, full, empty, done, running, 8'(CW'(DEPTH) - fill)};
  wire [15:0] st_lo = {8'(fill), dest, rd_en, wr_en, sync_en, 1'b0, err_en, start_q};
  wire        touch = (dat_wr || ((reg_wr || reg_rd) && reg_sel == 2'd1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdata   <= '0;
      bus_err <= 1'b0;
    end else begin
      bus_err <= err_en && !wr_en && !rd_en && touch;
      if (reg_rd)
        case (reg_sel)
          2'd0:    rdata <= {rd_en ? st_hi : 16'h0, st_lo};
          2'd1:    rdata <= rd_en ? 32'(len_cnt) : 32'h0;
          default: rdata <= 32'h0;
        endcase
    end
endmodule

module host_engine_fifo_chk #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int NDST  = 3,
  parameter int CW    = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic            reg_rd,
  input logic [1:0]      reg_sel,
  input logic            bus_err,
  input logic [CW-1:0]   fill,
  input logic            running,
  input logic            done,
  input logic [NDST-1:0] dst_valid,
  input logic [NDST-1:0] dst_ready,
  input logic [DW-1:0]   dst_data
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  assert_single_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dst_valid));
  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(dst_valid & ~dst_ready)) && !(reg_wr && reg_sel == 2'd0))
      |=> (dst_valid == $past(dst_valid) && $stable(dst_data)));
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!running && dst_valid == '0));
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> dst_valid == '0);
  assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(reg_wr || reg_rd));
endmodule

bind host_engine_fifo host_engine_fifo_chk #(.DW(DW), .DEPTH(DEPTH), .NDST(NDST), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
  .bus_err(bus_err), .fill(fill), .running(running), .done(done),
  .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data));

// File: tb/host_engine_fifo_bench.sv
`timescale 1ns/1ps
module host_engine_fifo_bench;
  localparam int DEPTH = 16;
  localparam logic [31:0] C_GO = 32'h1, C_ERR = 32'h2, C_CLR = 32'h4,
                          C_SYNC = 32'h8, C_WR = 32'h10, C_RD = 32'h20;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, sync_done = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] wdata = 0, rdata;
  logic bus_err;
  logic [2:0] dst_valid, dst_ready = 3'b111;
  logic [31:0] dst_data;

  int checks = 0, fails = 0, delivered = 0;
  logic [31:0] mbuf[$];
  logic [33:0] exp_q[$];
  logic wr_en_m = 0;

  always #2 clk = ~clk;

  host_engine_fifo u_host_engine_fifo (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .wdata(wdata), .rdata(rdata), .bus_err(bus_err), .sync_done(sync_done),
    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_sel = s; wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    reg_sel = s; reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = rdata;
  endtask

  task automatic cfg(input logic [31:0] v);
    wr(0, v);
    wr_en_m = v[4];
    if (v[2]) mbuf.delete();
  endtask

  task automatic push_word(input logic [31:0] d);
    wr(2, d);
    if (wr_en_m && mbuf.size() < DEPTH) mbuf.push_back(d);
  endtask

  task automatic launch(input logic [31:0] v, input int len);
    for (int i = 0; i < len; i++) exp_q.push_back({v[7:6], mbuf.pop_front()});
    cfg(v | C_GO);
  endtask

  task automatic wait_done(input string req, output logic [31:0] d);
    d = 0;
    for (int i = 0; i < 200 && !d[25]; i++) rd(0, d);
    chk(req, 32'(d[25]), 1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #1;
    if (rst_n && |(dst_valid & dst_ready)) begin
      delivered++;
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7 actual=unexpected word %0h expected=none", dst_data);
      end else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        chk("R5 data", dst_data, e[31:0]);
        chk("R5 port", 32'(dst_valid), 32'(3'b001 << e[33:32]));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(0, d);
    chk("R12 upper gated", d[31:16], 0);
    chk("R1 fill", d[15:8], 0);
    chk("R1 start", d[0], 0);
    cfg(C_RD);
    rd(0, d);
    chk("R1 free", d[23:16], DEPTH);
    chk("R1 flags", d[27:24], 4'b0100);

    push_word(32'hDEAD0000);
    rd(0, d);
    chk("R2 write ignored", d[15:8], 0);
    cfg(C_RD | C_WR);
    for (int i = 0; i < 3; i++) push_word(32'hA0 + i);
    rd(0, d);
    chk("R3 fill", d[15:8], 3);
    chk("R3 free", d[23:16], 13);

    cfg(32'hFFFF0000 | C_RD | C_WR);
    rd(0, d);
    chk("R13 status untouched", d[31:8], {4'b0, 4'b0000, 8'd13, 8'd3});

    wr(1, 2);
    launch(C_RD | C_WR | (1 << 6), 2);
    wait_done("R8 done", d);
    chk("R8 running cleared", d[24], 0);
    chk("R7 leftover", d[15:8], 1);
    rd(1, d);
    chk("R7 remaining", d, 0);
    chk("R7 all delivered", exp_q.size(), 0);

    sync_done = 0;
    wr(1, 1);
    launch(C_RD | C_WR | C_SYNC | (2 << 6), 1);
    repeat (3) @(negedge clk);
    rd(0, d);
    chk("R9 start held", d[0], 1);
    chk("R9 not running", d[24], 0);
    chk("R8 done cleared on start", d[25], 0);
    sync_done = 1;
    wait_done("R9 released", d);
    chk("R4 start reads 0", d[0], 0);
    sync_done = 0;

    dst_ready = 3'b000;
    for (int i = 0; i < 4; i++) push_word(32'hB0 + i);
    wr(1, 4);
    launch(C_RD | C_WR, 4);
    @(negedge clk);
    rd(0, d);
    chk("R4 running", d[24], 1);
    chk("R4 start cleared", d[0], 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R6 valid held", 32'(dst_valid), 1);
      chk("R6 data held", dst_data, 32'hB0);
    end
    dst_ready = 3'b111;
    wait_done("R8 stalled done", d);
    chk("R6 all delivered", delivered, 7);

    for (int i = 0; i < DEPTH + 1; i++) push_word(32'hC0 + i);
    rd(0, d);
    chk("R3 full fill", d[15:8], DEPTH);
    chk("R3 full flags", d[27:26], 2'b10);
    chk("R3 free zero", d[23:16], 0);

    wr(1, 2);
    cfg(C_RD | C_WR | (3 << 6) | C_GO);
    repeat (3) @(negedge clk);
    #1 chk("R5 unused dest silent", 32'(dst_valid), 0);
    rd(0, d);
    chk("R10 pre running", d[24], 1);
    cfg(C_RD | C_WR | C_CLR);
    rd(0, d);
    chk("R10 flushed", d[27:24], 4'b0100);
    chk("R10 fill", d[15:8], 0);

    cfg(C_ERR);
    wr(2, 32'h1);
    chk("R11 err on write", bus_err, 1);
    rd(1, d);
    chk("R11 err on length", bus_err, 1);
    chk("R12 length gated", d, 0);
    cfg(C_ERR | C_WR);
    push_word(32'h2);
    chk("R11 enabled no err", bus_err, 0);
    cfg(0);
    wr(2, 32'h3);
    chk("R11 err disabled", bus_err, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule